// File: doc/BRIEF.md
# Serial Three-Wire Command Front End

This block is the slave-side serial front end of a word-organised non-volatile memory. A fast system clock oversamples the chip select, serial clock, serial data input and protect-mode pin through two-flop synchronisers. Edges of the serial clock are detected in the system clock domain. After a select, the block skips leading zeros until a start bit arrives. It then shifts in a 2-bit opcode, an address and, for write-type commands, 16-bit data words. It decodes the command from the opcode together with the protect-mode pin.

Decoded commands go to the write sequencer and the protection logic as single-cycle strobes, each carrying its address and data. A separate pulse tells the sequencer when a complete programming command has been closed by deselection. Reads stream array words out MSB first through a tri-stateable data output, behind one leading dummy zero. They continue word after word with a wrapping address while the select is held. While a programming cycle runs, a reselected bus shows busy or ready on the output.

Top module: `mw_cmd_if`

## Requirements
- R1: A command starts only when chip select rises while the serial clock is low. Zeros sampled on rising serial clock edges before the first one are skipped, and that one is the start bit. A select that rises with the serial clock high is ignored until the next deselect.
- R2: After the start bit, the block samples the 2-bit opcode, then the ADDR_W-bit address, then 16-bit data words. Every field is MSB first and is sampled on the rising serial clock edge.
- R3: With the protect-mode pin low, opcode 10 gives READ (code 1), 01 gives WRITE (2) and 11 gives PAGE_WR (3). Opcode 00 decodes by the two top address bits: 01 gives WRITE_ALL (4), 11 gives WR_EN (5), 00 gives WR_DIS (6), and 10 gives no command.
- R4: With the protect-mode pin high, opcode 10 gives PROT_RD (7) and 01 gives PROT_WR (8). Opcode 11 gives PROT_CLR (9) only with an all-ones address. Opcode 00 gives PROT_EN (10) when the top two address bits are 11, and PROT_DIS (11) only with an all-zero address. Every other pattern gives no command.
- R5: Each decoded command raises cmd_valid_o for exactly one system clock, with its code on cmd_o and its address on cmd_addr_o. A pattern that decodes to no command (code 0) raises no strobe. Read and non-data commands strobe when the last address bit arrives. WRITE, PAGE_WR and WRITE_ALL strobe once per completed data word, with that word on cmd_data_o.
- R6: A READ drives sdo_oe_o high and outputs a 0 at the rising edge of the last address bit. On each following rising edge it outputs the next bit of the addressed word, MSB first.
- R7: While select stays high after a READ word, the address increments and the next word follows at once with no dummy bit. The address wraps from the highest value to 0.
- R8: A PROT_RD outputs a dummy 0, then prot_i[8:1] MSB first, then the flag prot_i[0].
- R9: A PAGE_WR accepts up to 4 words. After each word the low two address bits increment modulo 4, and the upper bits stay the same. Words beyond the fourth are ignored. WRITE and WRITE_ALL accept one word and ignore any further bits.
- R10: exec_o pulses once after deselect when the select carried at least one strobe of WRITE, PAGE_WR, WRITE_ALL, PROT_WR, PROT_CLR or PROT_DIS. A command cut short by deselect gives neither a strobe nor exec_o.
- R11: After a programming strobe, the next select drives sdo_oe_o high with sdo_o equal to not busy_i. Start bits are ignored while busy_i is high. A start bit taken while ready releases the output.
- R12: sdo_oe_o is low out of reset, and within three system clocks of chip select going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in, asynchronous |
| pre_i | input | 1 | Protect-mode select pin |
| busy_i | input | 1 | Programming cycle in progress, from sequencer |
| rd_data_i | input | DATA_W | Array word at rd_addr_o |
| prot_i | input | ADDR_W+1 | Protect register value and flag (bit 0) |
| rd_addr_o | output | ADDR_W | Current read address |
| cmd_valid_o | output | 1 | Command strobe |
| cmd_o | output | 4 | Command code |
| cmd_addr_o | output | ADDR_W | Command address |
| cmd_data_o | output | DATA_W | Command data word |
| exec_o | output | 1 | Programming command closed by deselect |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o |

## Verification
On every cycle, the assertions check four things. The output enable falls after deselect. A strobe lasts one cycle and never carries code 0. Every read strobe coincides with the enabled dummy zero. The execute pulse appears only with the select low. Only the bench scenarios can show the end-to-end behaviour: the decode table over both pin levels and all opcodes, the bit order and values of streamed words across the address wrap, page address stepping, the dropping of aborted or mis-started commands, and the busy/ready handshake.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [3:0] {
        CMD_NONE      = 4'd0,
        CMD_READ      = 4'd1,
        CMD_WRITE     = 4'd2,
        CMD_PAGE_WR   = 4'd3,
        CMD_WRITE_ALL = 4'd4,
        CMD_WR_EN     = 4'd5,
        CMD_WR_DIS    = 4'd6,
        CMD_PROT_RD   = 4'd7,
        CMD_PROT_WR   = 4'd8,
        CMD_PROT_CLR  = 4'd9,
        CMD_PROT_EN   = 4'd10,
        CMD_PROT_DIS  = 4'd11
    } mw_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_RD,
        ST_DONE
    } mw_state_e;

    // commands that start a self-timed programming cycle once deselected
    function automatic logic is_prog(input mw_cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_PAGE_WR) || (c == CMD_WRITE_ALL) ||
               (c == CMD_PROT_WR) || (c == CMD_PROT_CLR) || (c == CMD_PROT_DIS);
    endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] s_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign s_o = stg_q[STAGES-1];
endmodule

// File: rtl/mw_decode.sv
module mw_decode
    import mw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [1:0]        op_i,
    input  logic              pre_i,
    input  logic [ADDR_W-1:0] addr_i,
    output mw_cmd_e           cmd_o
);
    logic [1:0] top;
    assign top = addr_i[ADDR_W-1 -: 2];

    always_comb begin
        cmd_o = CMD_NONE;
        if (!pre_i) begin
            case (op_i)
                2'b10: cmd_o = CMD_READ;
                2'b01: cmd_o = CMD_WRITE;
                2'b11: cmd_o = CMD_PAGE_WR;
                default: begin
                    case (top)
                        2'b01:   cmd_o = CMD_WRITE_ALL;
                        2'b11:   cmd_o = CMD_WR_EN;
                        2'b00:   cmd_o = CMD_WR_DIS;
                        default: cmd_o = CMD_NONE;
                    endcase
                end
            endcase
        end else begin
            case (op_i)
                2'b10: cmd_o = CMD_PROT_RD;
                2'b01: cmd_o = CMD_PROT_WR;
                2'b11: cmd_o = (&addr_i) ? CMD_PROT_CLR : CMD_NONE;
                default: begin
                    if (top == 2'b11)       cmd_o = CMD_PROT_EN;
                    else if (addr_i == '0)  cmd_o = CMD_PROT_DIS;
                    else                    cmd_o = CMD_NONE;
                end
            endcase
        end
    end
endmodule

// File: rtl/mw_cmd_if.sv
module mw_cmd_if
    import mw_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int PAGE_WORDS = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              pre_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic [ADDR_W:0]   prot_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              cmd_valid_o,
    output logic [3:0]        cmd_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [DATA_W-1:0] cmd_data_o,
    output logic              exec_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam int PG_W  = $clog2(PAGE_WORDS);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [PG_W-1:0]  PG_LAST   = PG_W'(PAGE_WORDS - 1);
    localparam int PAD_W = DATA_W - ADDR_W - 1;

    typedef struct packed {
        mw_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        op;
        logic              pre;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [PG_W-1:0]   words;
        mw_cmd_e           cmd;
        logic [ADDR_W-1:0] oaddr;
        logic [DATA_W-1:0] odata;
        logic              sdo;
        logic              oe;
        logic              armed;
        logic              did_prog;
        logic              cmd_valid;
        logic              exec;
        logic              sck_prev;
    } mw_regs_t;

    mw_regs_t q, n;

    logic [3:0] sync_s;
    logic cs_s, sck_s, sdi_s, pre_s, sck_rise;
    logic [ADDR_W-1:0] addr_next;
    logic [DATA_W-1:0] data_next, rd_word;
    logic [CNT_W-1:0]  rd_idx;
    mw_cmd_e           dec_cmd;

    mw_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({pre_i, sdi_i, sck_i, cs_i}),
        .s_o   (sync_s)
    );

    assign {pre_s, sdi_s, sck_s, cs_s} = sync_s;
    assign sck_rise  = sck_s & ~q.sck_prev;
    assign addr_next = {q.addr[ADDR_W-2:0], sdi_s};
    assign data_next = {q.data[DATA_W-2:0], sdi_s};
    assign rd_word   = (q.cmd == CMD_PROT_RD) ? {prot_i, {PAD_W{1'b0}}} : rd_data_i;
    assign rd_idx    = DATA_LAST - q.cnt;

    mw_decode #(.ADDR_W(ADDR_W)) u_dec (
        .op_i   (q.op),
        .pre_i  (q.pre),
        .addr_i (addr_next),
        .cmd_o  (dec_cmd)
    );

    always_comb begin
        n           = q;
        n.cmd_valid = 1'b0;
        n.exec      = 1'b0;
        n.sck_prev  = sck_s;
        if (!cs_s) begin
            // deselect: abort any partial command, release the bus
            n.state    = ST_IDLE;
            n.oe       = 1'b0;
            n.sdo      = 1'b0;
            n.exec     = q.did_prog;
            n.did_prog = 1'b0;
        end else begin
            case (q.state)
                ST_IDLE: begin
                    n.cnt   = '0;
                    n.op    = '0;
                    n.addr  = '0;
                    n.state = sck_s ? ST_DONE : ST_START;
                end
                ST_START: begin
                    n.oe  = q.armed;
                    n.sdo = ~busy_i;
                    if (sck_rise && sdi_s && !busy_i) begin
                        n.state = ST_OPC;
                        n.armed = 1'b0;
                        n.oe    = 1'b0;
                        n.sdo   = 1'b0;
                    end
                end
                ST_OPC: if (sck_rise) begin
                    n.op  = {q.op[0], sdi_s};
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(1)) begin
                        n.state = ST_ADDR;
                        n.cnt   = '0;
                        n.pre   = pre_s;
                    end
                end
                ST_ADDR: if (sck_rise) begin
                    n.addr = addr_next;
                    n.cnt  = q.cnt + 1'b1;
                    if (q.cnt == ADDR_LAST) begin
                        n.cnt   = '0;
                        n.cmd   = dec_cmd;
                        n.oaddr = addr_next;
                        n.words = '0;
                        case (dec_cmd)
                            CMD_NONE: n.state = ST_DONE;
                            CMD_READ, CMD_PROT_RD: begin
                                n.state     = ST_RD;
                                n.cmd_valid = 1'b1;
                                n.oe        = 1'b1;
                                n.sdo       = 1'b0;
                            end
                            CMD_WRITE, CMD_PAGE_WR, CMD_WRITE_ALL: n.state = ST_DATA;
                            default: begin
                                n.state     = ST_DONE;
                                n.cmd_valid = 1'b1;
                                if (is_prog(dec_cmd)) begin
                                    n.did_prog = 1'b1;
                                    n.armed    = 1'b1;
                                end
                            end
                        endcase
                    end
                end
                ST_DATA: if (sck_rise) begin
                    n.data = data_next;
                    n.cnt  = q.cnt + 1'b1;
                    if (q.cnt == DATA_LAST) begin
                        n.cnt       = '0;
                        n.cmd_valid = 1'b1;
                        n.odata     = data_next;
                        n.oaddr     = q.addr;
                        n.did_prog  = 1'b1;
                        n.armed     = 1'b1;
                        if (q.cmd == CMD_PAGE_WR && q.words != PG_LAST) begin
                            n.words            = q.words + 1'b1;
                            n.addr[PG_W-1:0]   = q.addr[PG_W-1:0] + 1'b1;
                        end else begin
                            n.state = ST_DONE;
                        end
                    end
                end
                ST_RD: if (sck_rise) begin
                    n.sdo = rd_word[rd_idx];
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == DATA_LAST) begin
                        n.cnt = '0;
                        if (q.cmd == CMD_READ) n.addr = q.addr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign rd_addr_o   = q.addr;
    assign cmd_valid_o = q.cmd_valid;
    assign cmd_o       = q.cmd;
    assign cmd_addr_o  = q.oaddr;
    assign cmd_data_o  = q.odata;
    assign exec_o      = q.exec;
    assign sdo_o       = q.sdo;
    assign sdo_oe_o    = q.oe;

    a_r12_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !sdo_oe_o);
    a_r5_strobe_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_o != 4'd0));
    a_r5_strobe_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);
    a_r6_dummy_zero_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && (cmd_o == CMD_READ || cmd_o == CMD_PROT_RD)) |-> (sdo_oe_o && !sdo_o));
    a_r10_exec_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |-> $past(!cs_s));
endmodule

// File: tb/mw_cmd_if_tb.sv
module mw_cmd_if_tb;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cs = 1'b0, sck = 1'b0, sdi = 1'b0, pre = 1'b0, busy = 1'b0;
    logic [7:0]  rd_addr, cmd_addr;
    logic [15:0] rd_data, cmd_data;
    logic [8:0]  prot = 9'h14B;
    logic        cmd_valid, exec_p, sdo, sdo_oe;
    logic [3:0]  cmd;

    int checks = 0, errors = 0;
    bit done = 0;
    int n_strobe = 0, n_exec = 0;
    logic [3:0]  log_cmd  [64];
    logic [7:0]  log_addr [64];
    logic [15:0] log_data [64];

    always #10 clk = ~clk;

    function automatic logic [15:0] mem(input logic [7:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction

    assign rd_data = mem(rd_addr);

    mw_cmd_if u_dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi), .pre_i(pre),
        .busy_i(busy), .rd_data_i(rd_data), .prot_i(prot), .rd_addr_o(rd_addr),
        .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data),
        .exec_o(exec_p), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            log_cmd[n_strobe % 64]  <= cmd;
            log_addr[n_strobe % 64] <= cmd_addr;
            log_data[n_strobe % 64] <= cmd_data;
            n_strobe <= n_strobe + 1;
        end
        if (exec_p) n_exec <= n_exec + 1;
    end

    // expected code from the decode requirements R3/R4
    function automatic logic [3:0] exp_cmd(input logic p, input logic [1:0] op, input logic [7:0] a);
        if (!p) begin
            if (op == 2'b10) return 4'd1;
            if (op == 2'b01) return 4'd2;
            if (op == 2'b11) return 4'd3;
            if (a[7:6] == 2'b01) return 4'd4;
            if (a[7:6] == 2'b11) return 4'd5;
            if (a[7:6] == 2'b00) return 4'd6;
            return 4'd0;
        end
        if (op == 2'b10) return 4'd7;
        if (op == 2'b01) return 4'd8;
        if (op == 2'b11) return (a == 8'hFF) ? 4'd9 : 4'd0;
        if (a[7:6] == 2'b11) return 4'd10;
        if (a == 8'h00) return 4'd11;
        return 4'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic sbit(input logic b, output logic qv, output logic ev);
        sdi = b;
        tick(5);
        sck = 1'b1;
        tick(5);
        qv = sdo;
        ev = sdo_oe;
        sck = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int nb);
        logic qq, ee;
        for (int i = nb - 1; i >= 0; i--) sbit(v[i], qq, ee);
    endtask

    task automatic begin_cmd(input int zeros, input logic p);
        pre = p; sdi = 1'b0; sck = 1'b0; cs = 1'b1;
        tick(5);
        send(32'd0, zeros);
        send(32'd1, 1);
    endtask

    task automatic header(input logic [1:0] op, input logic [7:0] a, output logic qv, output logic ev);
        send({30'd0, op}, 2);
        send({25'd0, a[7:1]}, 7);
        sbit(a[0], qv, ev);
    endtask

    task automatic read_word(output logic [15:0] w);
        logic qv, ev;
        for (int i = 15; i >= 0; i--) begin
            sbit(1'b0, qv, ev);
            w[i] = qv;
        end
    endtask

    task automatic deselect();
        sdi = 1'b0; cs = 1'b0;
        tick(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic qv, ev;
        logic [15:0] w;
        int sb, eb;
        logic [7:0] rd_list [8];
        logic [7:0] dec_list [6];
        rd_list  = '{8'h00, 8'h01, 8'h37, 8'h80, 8'hAA, 8'hC3, 8'hFE, 8'hFF};
        dec_list = '{8'h00, 8'h12, 8'h47, 8'h80, 8'hC5, 8'hFF};

        tick(4);
        rst_n = 1'b1;
        tick(4);
        chk("R12 reset oe", sdo_oe, 0);
        chk("R5 reset strobe", cmd_valid, 0);

        // R1 R2 R6 R3 R5: single-word reads with varying leading zeros
        for (int i = 0; i < 8; i++) begin
            sb = n_strobe;
            begin_cmd(i % 4, 1'b0);
            header(2'b10, rd_list[i], qv, ev);
            chk("R6 dummy bit", {ev, qv}, 2'b10);
            read_word(w);
            chk("R6 read word", w, mem(rd_list[i]));
            chk("R5 read strobe count", n_strobe - sb, 1);
            chk("R3 read code", log_cmd[sb % 64], 1);
            chk("R2 read address", log_addr[sb % 64], rd_list[i]);
            deselect();
            chk("R12 oe after deselect", sdo_oe, 0);
        end

        // R7: streaming across the wrap
        begin_cmd(0, 1'b0);
        header(2'b10, 8'hFE, qv, ev);
        for (int k = 0; k < 3; k++) begin
            read_word(w);
            chk("R7 sequential word", w, mem(8'(8'hFE + k)));
        end
        deselect();

        // R8: protect read
        begin_cmd(2, 1'b1);
        header(2'b10, 8'h00, qv, ev);
        chk("R8 dummy bit", {ev, qv}, 2'b10);
        w = '0;
        for (int i = 8; i >= 0; i--) begin
            sbit(1'b0, qv, ev);
            w[i] = qv;
        end
        chk("R8 register and flag", w, 16'(prot));
        deselect();

        // R9 R10: page write from 0x05 with five words
        sb = n_strobe; eb = n_exec;
        begin_cmd(1, 1'b0);
        header(2'b11, 8'h05, qv, ev);
        for (int k = 0; k < 5; k++) send(32'(16'h1111 * (k + 1)), 16);
        deselect();
        tick(4);
        chk("R9 page strobes", n_strobe - sb, 4);
        for (int k = 0; k < 4; k++) begin
            chk("R9 page address", log_addr[(sb + k) % 64], {6'b000001, 2'(k + 1)});
            chk("R9 page data", log_data[(sb + k) % 64], 16'h1111 * (k + 1));
        end
        chk("R10 page exec", n_exec - eb, 1);

        // R3 R4 R5 R10: decode sweep over pin level, opcode and address class
        for (int p = 0; p < 2; p++) begin
            for (int op = 0; op < 4; op++) begin
                for (int j = 0; j < 6; j++) begin
                    logic [3:0] ec;
                    logic [15:0] dv;
                    ec = exp_cmd(p[0], op[1:0], dec_list[j]);
                    dv = 16'hC3A5 ^ {dec_list[j], dec_list[j]};
                    sb = n_strobe; eb = n_exec;
                    begin_cmd(j % 3, p[0]);
                    header(op[1:0], dec_list[j], qv, ev);
                    if (ec == 4'd2 || ec == 4'd3 || ec == 4'd4) send({16'd0, dv}, 16);
                    deselect();
                    tick(4);
                    chk(p ? "R4 strobe count" : "R3 strobe count", n_strobe - sb, (ec != 0) ? 1 : 0);
                    if (ec != 0) begin
                        chk(p ? "R4 code" : "R3 code", log_cmd[sb % 64], ec);
                        chk("R5 address", log_addr[sb % 64], dec_list[j]);
                        if (ec == 4'd2 || ec == 4'd3 || ec == 4'd4)
                            chk("R5 data", log_data[sb % 64], dv);
                    end
                    chk("R10 exec count", n_exec - eb,
                        (ec == 2 || ec == 3 || ec == 4 || ec == 8 || ec == 9 || ec == 11) ? 1 : 0);
                end
            end
        end

        // R10: aborted commands
        sb = n_strobe; eb = n_exec;
        begin_cmd(0, 1'b0);
        send(32'b01, 2);
        send(32'b1010, 4);
        deselect();
        begin_cmd(0, 1'b0);
        header(2'b01, 8'h33, qv, ev);
        send(32'h1F, 9);
        deselect();
        tick(4);
        chk("R10 abort strobe", n_strobe - sb, 0);
        chk("R10 abort exec", n_exec - eb, 0);

        // R1: select rising while serial clock is high
        sb = n_strobe;
        sck = 1'b1; tick(6);
        cs = 1'b1; tick(6);
        sck = 1'b0;
        send(32'd1, 1);
        header(2'b10, 8'h21, qv, ev);
        chk("R1 ignored select oe", ev, 0);
        deselect();
        chk("R1 ignored select strobe", n_strobe - sb, 0);

        // R9 R10 R11: single write, extra word ignored, busy/ready status
        sb = n_strobe; eb = n_exec;
        begin_cmd(0, 1'b0);
        header(2'b01, 8'h10, qv, ev);
        send(32'hBEEF, 16);
        send(32'h1234, 16);
        deselect();
        busy = 1'b1;
        tick(4);
        chk("R9 write strobe count", n_strobe - sb, 1);
        chk("R10 write exec", n_exec - eb, 1);
        cs = 1'b1; tick(8);
        chk("R11 busy shown", {sdo_oe, sdo}, 2'b10);
        send(32'b110, 3);
        chk("R11 start ignored while busy", {sdo_oe, sdo}, 2'b10);
        busy = 1'b0; tick(6);
        chk("R11 ready shown", {sdo_oe, sdo}, 2'b11);
        send(32'd1, 1);
        tick(2);
        chk("R11 output released", sdo_oe, 0);
        header(2'b10, 8'h20, qv, ev);
        chk("R11 command after ready", {ev, qv}, 2'b10);
        deselect();
        chk("R12 final oe", sdo_oe, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule